// File: doc/BRIEF.md
# Protected clock-control register bank

This block is a small bank of clock-configuration registers on a plain CPU bus with an address, write data, a write strobe and combinational read data. It holds the settings that a clock generator, a watchdog and an interrupt controller consume. It does not generate clocks, run a PLL, drive oscillators or count for the watchdog. It only stores settings and drives the decoded control outputs.

Two kinds of protection guard the settings:

- **Write-enable bits.** A small guard register holds two enable bits. Each bit must be set before its target register accepts a write.
- **Write-once lock bits.** A mode register holds lock bits that, once set, can only be cleared by reset. While a lock is set, the bank drops writes to selected clock, stop-mode and PLL fields one field at a time. Neighbouring fields in the same word stay writable.

The two lock bits are held in a four-state lock machine:

| State | Meaning |
|-------|---------|
| `LK_OPEN` | Neither lock is set |
| `LK_SYS` | Only the system-clock lock is set |
| `LK_WDT` | Only the watchdog-source lock is set |
| `LK_BOTH` | Both locks are set |

Transitions:

- `LK_OPEN` goes to `LK_SYS` on an accepted mode write with bit 1 only.
- `LK_OPEN` goes to `LK_WDT` on an accepted mode write with bit 2 only.
- `LK_OPEN` goes to `LK_BOTH` on an accepted mode write with both bits.
- `LK_SYS` goes to `LK_BOTH` on an accepted mode write with bit 2.
- `LK_WDT` goes to `LK_BOTH` on an accepted mode write with bit 1.
- `LK_BOTH` holds.
- No state returns to a lower state except through reset.

Register addresses:

| Address | Register |
|---------|----------|
| 0 | Guard |
| 1 | Peripheral clock select |
| 2 | Mode |
| 3 | Clock control |
| 4 | Stop request (write only) |
| 5 | PLL control |

Top module: `clk_ctrl_bank`

## Requirements
- R1: The guard register at address 0 is writable at any time and stores data bits 1:0. Bit 0 is the peripheral-select write enable and bit 1 is the mode write enable. It resets to 0 and reads return 0 in bits 7:2.
- R2: The peripheral clock select at address 1 accepts a write only while guard bit 0 is 1. It resets to 0x03 and reads return 0 in bits 7:2. `tmr_clk_div2` is the inverse of bit 0 and `ser_clk_div2` is the inverse of bit 1; a 0 in either bit selects divide-by-2.
- R3: The mode register at address 2 accepts a write only while guard bit 1 is 1. It resets to 0. Reads return bit 0 = wait, bit 1 = system-clock lock, bit 2 = watchdog-source lock and bit 4 = NMI enable, with bits 3 and 7:5 always reading 0.
- R4: Mode bit 0 (wait select) changes only on a mode write made while PLL control bit 7 (PLL on) is 0. `sfr_wait_cnt` is 1 when PLL on and mode bit 0 are both 1, and 2 otherwise.
- R5: Mode bit 1 (system-clock lock) is set by writing 1 and is never cleared by a later write. Only reset clears it.
- R6: While the system-clock lock is 1, the bank holds two sets of fields. In the clock-control register at address 3 it holds bit 0 (main clock stop, `main_clk_stop`), bits 2:1 (CPU clock source, `cpu_clk_sel`) and bit 3 (oscillation-stop detect enable, `osc_det_en`). It also holds the whole PLL control register at address 5 (`pll_cfg`). Clock-control bits 7:4 stay writable. With the lock clear, addresses 3 and 5 take any write.
- R7: Mode bit 2 (watchdog-source lock) is write-once. While it is 1, both `wdt_src_osc` and `osc_force_on` are 1.
- R8: Mode bit 4 is write-once. `nmi_pin_en` follows it: 0 means the pin is a general-purpose pin and 1 means the pin is NMI.
- R9: `stop_blocked` is 1 whenever either lock is set. A write to address 4 with data bit 0 = 1 raises `stop_enter` for exactly the next cycle, unless `stop_blocked` was 1 in the write cycle; in that case no pulse occurs.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (3) | Register address |
| bus_wdata | input | DW (8) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DW (8) | Read data for bus_addr |
| tmr_clk_div2 | output | 1 | Timer clock uses divide-by-2 |
| ser_clk_div2 | output | 1 | Serial clock uses divide-by-2 |
| sfr_wait_cnt | output | 2 | Register access wait states (1 or 2) |
| wdt_src_osc | output | 1 | Watchdog counts the on-chip oscillator |
| osc_force_on | output | 1 | On-chip oscillator forced running |
| nmi_pin_en | output | 1 | Shared pin acts as NMI |
| stop_blocked | output | 1 | Stop-mode requests are refused |
| stop_enter | output | 1 | One-cycle stop-mode entry pulse |
| main_clk_stop | output | 1 | Main clock stop control |
| cpu_clk_sel | output | 2 | CPU clock source select |
| osc_det_en | output | 1 | Oscillation-stop detect enable |
| pll_cfg | output | DW (8) | PLL control word |

## Verification
One mode-register write can do several things in the same cycle:

- set a lock bit,
- change the wait bit,
- set the NMI bit.

The very next write may then be a gated write that the new lock must already refuse. The PLL-on bit also decides in the same cycle whether the wait field of a mode write is accepted.

The bench provokes these collisions in two ways:

- Directed sequences place a locking mode write directly before a clock-control, PLL or stop write.
- Random bursts mix mode and PLL writes with random guard settings.

A reference model built from the requirements judges each outcome. The bench compares every readable register and every output after each write, and compares the stop pulse in the cycle after the write.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
    localparam int unsigned BUS_AW = 3;
    localparam int unsigned BUS_DW = 8;

    localparam int unsigned ADR_GUARD = 0;
    localparam int unsigned ADR_PCLK  = 1;
    localparam int unsigned ADR_MODE  = 2;
    localparam int unsigned ADR_CCR   = 3;
    localparam int unsigned ADR_STOP  = 4;
    localparam int unsigned ADR_PLL   = 5;

    typedef enum logic [1:0] {
        LK_OPEN = 2'd0,
        LK_SYS  = 2'd1,
        LK_WDT  = 2'd2,
        LK_BOTH = 2'd3
    } lock_state_e;
endpackage

// File: rtl/cb_lock_fsm.sv
module cb_lock_fsm
    import clkbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_sys,
    input  logic set_wdt,
    output logic sys_lock,
    output logic wdt_lock,
    output logic stop_blocked
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: begin
                if (set_sys && set_wdt) state_d = LK_BOTH;
                else if (set_sys)       state_d = LK_SYS;
                else if (set_wdt)       state_d = LK_WDT;
            end
            LK_SYS:  if (set_wdt) state_d = LK_BOTH;
            LK_WDT:  if (set_sys) state_d = LK_BOTH;
            LK_BOTH: state_d = LK_BOTH;
        endcase
    end

    always_comb begin
        sys_lock = 1'b0;
        wdt_lock = 1'b0;
        unique case (state_q)
            LK_OPEN: ;
            LK_SYS:  sys_lock = 1'b1;
            LK_WDT:  wdt_lock = 1'b1;
            LK_BOTH: begin
                sys_lock = 1'b1;
                wdt_lock = 1'b1;
            end
        endcase
        stop_blocked = sys_lock | wdt_lock;
    end
endmodule

// File: rtl/cb_prot_regs.sv
module cb_prot_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_guard,
    input  logic       we_pclk,
    input  logic       we_mode,
    input  logic [1:0] wd_lo,
    input  logic       wd_b2,
    input  logic       wd_b4,
    input  logic       pll_on,
    output logic [1:0] guard_q,
    output logic [1:0] pclk_q,
    output logic       wait_q,
    output logic       nmi_q,
    output logic       set_sys,
    output logic       set_wdt
);
    logic mode_ok;

    assign mode_ok = we_mode & guard_q[1];
    assign set_sys = mode_ok & wd_lo[1];
    assign set_wdt = mode_ok & wd_b2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= 2'b00;
            pclk_q  <= 2'b11;
            wait_q  <= 1'b0;
            nmi_q   <= 1'b0;
        end else begin
            if (we_guard) guard_q <= wd_lo;
            if (we_pclk && guard_q[0]) pclk_q <= wd_lo;
            if (mode_ok && !pll_on) wait_q <= wd_lo[0];
            if (mode_ok && wd_b4) nmi_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cb_clk_regs.sv
module cb_clk_regs #(
    parameter int unsigned DW        = 8,
    parameter int unsigned LOCK_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_ccr,
    input  logic          we_stop,
    input  logic          we_pll,
    input  logic [DW-1:0] wdata,
    input  logic          sys_lock,
    input  logic          stop_blocked,
    output logic [DW-1:0] ccr_q,
    output logic [DW-1:0] pll_q,
    output logic          stop_pulse
);
    localparam logic [DW-1:0] LOCK_MASK = DW'((1 << LOCK_BITS) - 1);

    logic [DW-1:0] ccr_next;

    always_comb begin
        if (sys_lock) ccr_next = (ccr_q & LOCK_MASK) | (wdata & ~LOCK_MASK);
        else          ccr_next = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q      <= '0;
            pll_q      <= '0;
            stop_pulse <= 1'b0;
        end else begin
            stop_pulse <= we_stop & wdata[0] & ~stop_blocked;
            if (we_ccr) ccr_q <= ccr_next;
            if (we_pll && !sys_lock) pll_q <= wdata;
        end
    end
endmodule

// File: rtl/clk_ctrl_bank.sv
module clk_ctrl_bank
    import clkbank_pkg::*;
#(
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned DW = BUS_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    output logic          tmr_clk_div2,
    output logic          ser_clk_div2,
    output logic [1:0]    sfr_wait_cnt,
    output logic          wdt_src_osc,
    output logic          osc_force_on,
    output logic          nmi_pin_en,
    output logic          stop_blocked,
    output logic          stop_enter,
    output logic          main_clk_stop,
    output logic [1:0]    cpu_clk_sel,
    output logic          osc_det_en,
    output logic [DW-1:0] pll_cfg
);
    localparam int unsigned PLL_ON_BIT = DW - 1;
    localparam int unsigned LOCK_BITS  = 4;

    logic          sel_guard, sel_pclk, sel_mode, sel_ccr, sel_stop, sel_pll;
    logic [1:0]    guard_q, pclk_q;
    logic          wait_q, nmi_q, set_sys, set_wdt;
    logic          sys_lock, wdt_lock;
    logic [DW-1:0] ccr_q, pll_q;
    logic          pll_on;

    assign sel_guard = bus_we && (bus_addr == AW'(ADR_GUARD));
    assign sel_pclk  = bus_we && (bus_addr == AW'(ADR_PCLK));
    assign sel_mode  = bus_we && (bus_addr == AW'(ADR_MODE));
    assign sel_ccr   = bus_we && (bus_addr == AW'(ADR_CCR));
    assign sel_stop  = bus_we && (bus_addr == AW'(ADR_STOP));
    assign sel_pll   = bus_we && (bus_addr == AW'(ADR_PLL));
    assign pll_on    = pll_q[PLL_ON_BIT];

    cb_prot_regs u_prot (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_guard (sel_guard),
        .we_pclk  (sel_pclk),
        .we_mode  (sel_mode),
        .wd_lo    (bus_wdata[1:0]),
        .wd_b2    (bus_wdata[2]),
        .wd_b4    (bus_wdata[4]),
        .pll_on   (pll_on),
        .guard_q  (guard_q),
        .pclk_q   (pclk_q),
        .wait_q   (wait_q),
        .nmi_q    (nmi_q),
        .set_sys  (set_sys),
        .set_wdt  (set_wdt)
    );

    cb_lock_fsm u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_sys      (set_sys),
        .set_wdt      (set_wdt),
        .sys_lock     (sys_lock),
        .wdt_lock     (wdt_lock),
        .stop_blocked (stop_blocked)
    );

    cb_clk_regs #(.DW(DW), .LOCK_BITS(LOCK_BITS)) u_clk (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_ccr       (sel_ccr),
        .we_stop      (sel_stop),
        .we_pll       (sel_pll),
        .wdata        (bus_wdata),
        .sys_lock     (sys_lock),
        .stop_blocked (stop_blocked),
        .ccr_q        (ccr_q),
        .pll_q        (pll_q),
        .stop_pulse   (stop_enter)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (int'(bus_addr))
            ADR_GUARD: bus_rdata[1:0] = guard_q;
            ADR_PCLK:  bus_rdata[1:0] = pclk_q;
            ADR_MODE: begin
                bus_rdata[0] = wait_q;
                bus_rdata[1] = sys_lock;
                bus_rdata[2] = wdt_lock;
                bus_rdata[4] = nmi_q;
            end
            ADR_CCR:   bus_rdata = ccr_q;
            ADR_PLL:   bus_rdata = pll_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign tmr_clk_div2  = ~pclk_q[0];
    assign ser_clk_div2  = ~pclk_q[1];
    assign sfr_wait_cnt  = (pll_on && wait_q) ? 2'd1 : 2'd2;
    assign wdt_src_osc   = wdt_lock;
    assign osc_force_on  = wdt_lock;
    assign nmi_pin_en    = nmi_q;
    assign main_clk_stop = ccr_q[0];
    assign cpu_clk_sel   = ccr_q[2:1];
    assign osc_det_en    = ccr_q[3];
    assign pll_cfg       = pll_q;
endmodule

// File: rtl/cb_checker.sv
module cb_checker #(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_we,
    input logic          sys_lock,
    input logic          wdt_lock,
    input logic          nmi_q,
    input logic          wait_q,
    input logic          pll_on,
    input logic [1:0]    guard_q,
    input logic [1:0]    pclk_q,
    input logic [DW-1:0] ccr_q,
    input logic [DW-1:0] pll_cfg,
    input logic          stop_blocked,
    input logic          stop_enter,
    input logic          wdt_src_osc,
    input logic          osc_force_on
);
    // R2
    pclk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_q[0] |=> $stable(pclk_q));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_on |=> $stable(wait_q));

    // R5
    sys_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_lock |=> sys_lock);

    // R6
    pll_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_lock |=> $stable(pll_cfg));

    // R6
    ccr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_lock |=> $stable(ccr_q[3:0]));

    // R7
    wdt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_lock |=> wdt_lock);

    // R7
    wdt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_lock |-> (wdt_src_osc && osc_force_on));

    // R8
    nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |=> nmi_q);

    // R9
    stop_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_blocked |=> !stop_enter);

    // R9
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |-> $past(bus_we && (bus_addr == AW'(4)) && bus_wdata[0]));
endmodule

bind clk_ctrl_bank cb_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .sys_lock     (sys_lock),
    .wdt_lock     (wdt_lock),
    .nmi_q        (nmi_q),
    .wait_q       (wait_q),
    .pll_on       (pll_on),
    .guard_q      (guard_q),
    .pclk_q       (pclk_q),
    .ccr_q        (ccr_q),
    .pll_cfg      (pll_cfg),
    .stop_blocked (stop_blocked),
    .stop_enter   (stop_enter),
    .wdt_src_osc  (wdt_src_osc),
    .osc_force_on (osc_force_on)
);

// File: tb/sim_clk_ctrl_bank.sv
`timescale 1ns/1ps
module sim_clk_ctrl_bank;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_we;
    logic [7:0] bus_rdata;
    logic       tmr_clk_div2, ser_clk_div2, wdt_src_osc, osc_force_on;
    logic       nmi_pin_en, stop_blocked, stop_enter, main_clk_stop, osc_det_en;
    logic [1:0] sfr_wait_cnt, cpu_clk_sel;
    logic [7:0] pll_cfg;

    int total = 0;
    int bad   = 0;

    logic [1:0] m_guard, m_pclk;
    logic       m_wait, m_sys, m_wdt, m_nmi;
    logic [7:0] m_ccr, m_pll;
    logic       seen_stop;

    always #5 clk = ~clk;

    clk_ctrl_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .tmr_clk_div2(tmr_clk_div2),
        .ser_clk_div2(ser_clk_div2), .sfr_wait_cnt(sfr_wait_cnt),
        .wdt_src_osc(wdt_src_osc), .osc_force_on(osc_force_on),
        .nmi_pin_en(nmi_pin_en), .stop_blocked(stop_blocked),
        .stop_enter(stop_enter), .main_clk_stop(main_clk_stop),
        .cpu_clk_sel(cpu_clk_sel), .osc_det_en(osc_det_en), .pll_cfg(pll_cfg)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_mode();
        return {3'b000, m_nmi, 1'b0, m_wdt, m_sys, m_wait};
    endfunction

    function automatic logic [1:0] exp_waits();
        return (m_pll[7] && m_wait) ? 2'd1 : 2'd2;
    endfunction

    task automatic model_reset();
        m_guard = 2'b00; m_pclk = 2'b11; m_wait = 1'b0; m_sys = 1'b0;
        m_wdt = 1'b0; m_nmi = 1'b0; m_ccr = 8'h00; m_pll = 8'h00;
    endtask

    task automatic model_write(int a, logic [7:0] d);
        case (a)
            0: m_guard = d[1:0];
            1: if (m_guard[0]) m_pclk = d[1:0];
            2: if (m_guard[1]) begin
                if (!m_pll[7]) m_wait = d[0];
                if (d[1]) m_sys = 1'b1;
                if (d[2]) m_wdt = 1'b1;
                if (d[4]) m_nmi = 1'b1;
            end
            3: m_ccr = m_sys ? {d[7:4], m_ccr[3:0]} : d;
            5: if (!m_sys) m_pll = d;
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic bus_write(int a, logic [7:0] d);
        logic exp_stop;
        exp_stop = (a == 4) && d[0] && !(m_sys || m_wdt);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        seen_stop = stop_enter;
        // R9 pulse in the cycle after the stop write
        check("R9 stop_enter", {7'b0, seen_stop}, {7'b0, exp_stop});
        model_write(a, d);
    endtask

    task automatic read_chk(int a, logic [7:0] exp, string req);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic check_all();
        read_chk(0, {6'b0, m_guard}, "R1 guard read");
        read_chk(1, {6'b0, m_pclk}, "R2 pclk read");
        read_chk(2, exp_mode(), "R3/R5/R7/R8 mode read");
        read_chk(3, m_ccr, "R6 ccr read");
        read_chk(5, m_pll, "R6 pll read");
        read_chk(6, 8'h00, "R10 unmapped read");
        read_chk(7, 8'h00, "R10 unmapped read");
        check("R2 timer div", {7'b0, tmr_clk_div2}, {7'b0, ~m_pclk[0]});
        check("R2 serial div", {7'b0, ser_clk_div2}, {7'b0, ~m_pclk[1]});
        check("R4 wait count", {6'b0, sfr_wait_cnt}, {6'b0, exp_waits()});
        check("R7 wdt source", {6'b0, wdt_src_osc, osc_force_on}, {6'b0, m_wdt, m_wdt});
        check("R8 nmi pin", {7'b0, nmi_pin_en}, {7'b0, m_nmi});
        check("R9 stop_blocked", {7'b0, stop_blocked}, {7'b0, m_sys | m_wdt});
        check("R6 ccr fields", {4'b0, osc_det_en, cpu_clk_sel, main_clk_stop}, {4'b0, m_ccr[3:0]});
        check("R6 pll out", pll_cfg, m_pll);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        do_reset();
        check_all();                           // reset state R1 R2 R3

        bus_write(1, 8'h00); check_all();      // R2 ignored without guard bit 0
        bus_write(2, 8'h17); check_all();      // R3 ignored without guard bit 1
        bus_write(0, 8'hFF); check_all();      // R1 only bits 1:0 stored
        bus_write(1, 8'hFE); check_all();      // R2 bit1 kept, bit0 -> div2
        bus_write(5, 8'h80); check_all();      // PLL on
        bus_write(2, 8'h01); check_all();      // R4 wait write refused, PLL on
        bus_write(5, 8'h00); bus_write(2, 8'h01); bus_write(5, 8'h80);
        check_all();                           // R4 one wait
        bus_write(4, 8'h01); check_all();      // R9 pulse while unlocked
        bus_write(6, 8'hAA); bus_write(7, 8'h55); check_all(); // R10
        bus_write(3, 8'h5A); check_all();
        bus_write(2, 8'h12); check_all();      // R5 R8 lock + NMI in one write
        bus_write(3, 8'hF5); check_all();      // R6 low nibble held
        bus_write(5, 8'h11); check_all();      // R6 PLL held
        bus_write(2, 8'h00); check_all();      // R5 R8 cannot clear
        bus_write(4, 8'h01); check_all();      // R9 refused
        do_reset(); check_all();
        bus_write(0, 8'h02); bus_write(2, 8'h04); check_all(); // R7
        bus_write(4, 8'h01); check_all();      // R9 refused under watchdog lock
        bus_write(3, 8'h0F); check_all();      // R6 ccr free without system lock

        for (int burst = 0; burst < 12; burst++) begin
            do_reset();
            for (int n = 0; n < 30; n++) begin
                int a;
                logic [7:0] d;
                a = int'($urandom_range(0, 7));
                d = 8'($urandom());
                if (a == 2 && ($urandom_range(0, 3) != 0)) d[2:1] = 2'b00;
                bus_write(a, d);
                check_all();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule